// File: doc/BRIEF.md
# DCC Packet Bit Sequencer

This block turns queued DCC packets into a stream of line-symbol codes. A separate waveform stage times each symbol's half-periods. A packet arrives as a flat byte field, a byte count and a repeat count. The sequencer reads the packet when it emits the packet's start bit. It pulses `pkt_ready` to remove the packet from the external queue once the last repetition has been sent. If no packet is waiting when the start bit goes out, the sequencer sends a built-in idle packet instead.

Each `sym_done` pulse from the waveform stage advances the sequencer by one bit slot. The next symbol code then appears with a one-cycle `sym_load` strobe. After the end bit the sequencer takes one of two tails:

- If any output requests a cutout, it opens a four-phase cutout window. During that window it reports the phase and the phase duration, and it drives per-output cutout enables.
- Otherwise it sends a short tail of ones that closes with a special end-of-packet one symbol.

An option replaces the first preamble slot with a half-zero symbol and lengthens the preamble.

Top module: `dcc_bit_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `sym_code` to one (1) and clears `sym_load`, `pkt_ready`, `pkt_next`, `cut_open` and `cut_en`. The first slot after reset is the first preamble slot.
- R2: Each `sym_done` pulse produces exactly one `sym_load` pulse on the next cycle. Without `sym_done`, `sym_load` stays low and `sym_code` holds. The symbol codes are: 0 zero, 1 one, 2 half-zero, 3 end-of-packet one, 4 cutout one, 5 cutout post. No other value appears.
- R3: With the half-zero option off, the packet starts with PREAMBLE_LEN-1 one symbols and then a single zero start bit.
- R4: `half_zero_en` is sampled at the first preamble slot. When it is high, that slot carries code 2, twenty ones follow (21 preamble slots in all), and then the zero start bit.
- R5: Data bytes are sent in order, byte 0 first, where byte 0 is `pkt_data[7:0]`. Each byte is sent most significant bit first. A zero separator follows every byte except the last. A one end bit follows the last byte.
- R6: If `cutout_req` is all zero at the slot after the end bit, the tail is four one symbols followed by one end-of-packet symbol (code 3). The packet ends with that symbol.
- R7: If any `cutout_req` bit is set at the slot after the end bit, the tail is codes 4, 4, 4, 5. `cut_open` is high and `cut_phase` reads 0, 1, 2, 3 (pre, first, middle, post). The packet ends with the post symbol.
- R8: `cut_en` takes the value of `cutout_req` with the phase-1 load, holds through phase 2 and clears with the phase-3 load. `cut_en` is never nonzero while `cut_open` is low.
- R9: `cut_len_us` gives CUT_PRE_US, CUT_FIRST_US and CUT_MID_US for phases 0 to 2. For phase 3 it gives the remainder of a 504 + POST_DELTA_US µs budget, which the waveform stage fills as driven-high time.
- R10: `pkt_next` pulses together with the load of every packet's last symbol. A queued packet is sent `pkt_repeat`+1 times. `pkt_ready` pulses only together with the `pkt_next` of the final repetition.
- R11: If `pkt_valid` is low when the start bit is emitted, the idle packet is sent. The idle packet is three bytes, 0xFF 0x00 0xFF, sent once, and it never pulses `pkt_ready`.
- R12: A packet is captured on the slot that emits the start bit. A packet offered partway through the preamble is still sent in that same packet slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A queued packet is present at the queue head |
| pkt_ready | output | 1 | One-cycle pulse: remove the head packet |
| pkt_data | input | 8*MAX_BYTES | Packet bytes; byte 0 in bits 7:0 |
| pkt_len | input | LEN_W | Number of bytes, 1 to MAX_BYTES |
| pkt_repeat | input | REP_W | Extra repetitions of the packet |
| half_zero_en | input | 1 | Begin the preamble with a half-zero slot |
| cutout_req | input | NOUT | Per-output cutout request |
| sym_done | input | 1 | Waveform stage finished the current symbol |
| sym_load | output | 1 | New symbol code is valid |
| sym_code | output | 3 | Current symbol code |
| pkt_next | output | 1 | Pulse: the current packet slot ends with this symbol |
| cut_open | output | 1 | Current symbol belongs to the cutout window |
| cut_phase | output | 2 | Cutout phase 0 to 3 |
| cut_len_us | output | 10 | Duration of the current cutout phase in µs |
| cut_en | output | NOUT | Per-output cutout-active flags |

## Verification
The hardest situation to reach from the ports is the end of a repeated packet's last pass. On that one load, `pkt_ready` must coincide with `pkt_next`, and the earlier passes must never pulse it. The bench holds a one-byte packet valid across three complete passes and checks the pop flag on every slot of each pass. To cover R12, the bench offers another packet only after several preamble slots have already gone out. The cutout-enable snapshot is checked phase by phase with a sparse request pattern, so that a mixed-up bit order or a stale flag would show.

// File: rtl/dcc_bit_sequencer.sv
module dcc_bit_sequencer #(
  parameter int MAX_BYTES     = 6,
  parameter int PREAMBLE_LEN  = 17,
  parameter int REP_W         = 3,
  parameter int NOUT          = 3,
  parameter int CUT_PRE_US    = 26,
  parameter int CUT_FIRST_US  = 160,
  parameter int CUT_MID_US    = 190,
  parameter int POST_DELTA_US = 0,
  localparam int LEN_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pkt_valid,
  output logic                   pkt_ready,
  input  logic [8*MAX_BYTES-1:0] pkt_data,
  input  logic [LEN_W-1:0]       pkt_len,
  input  logic [REP_W-1:0]       pkt_repeat,
  input  logic                   half_zero_en,
  input  logic [NOUT-1:0]        cutout_req,
  input  logic                   sym_done,
  output logic                   sym_load,
  output logic [2:0]             sym_code,
  output logic                   pkt_next,
  output logic                   cut_open,
  output logic [1:0]             cut_phase,
  output logic [9:0]             cut_len_us,
  output logic [NOUT-1:0]        cut_en
);
  localparam int BYTE_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int PRE_MAX = (PREAMBLE_LEN > 22) ? PREAMBLE_LEN : 22;
  localparam int CNT_W   = $clog2(PRE_MAX + 1);
  localparam int CUT_POST_US = 5*2*56 - 56 + POST_DELTA_US - CUT_PRE_US - CUT_FIRST_US - CUT_MID_US;
  localparam logic [CNT_W-1:0] NEED_PLAIN = CNT_W'(PREAMBLE_LEN - 1);
  localparam logic [CNT_W-1:0] NEED_HZ    = CNT_W'(21);
  localparam logic [8*MAX_BYTES-1:0] IDLE_PKT = (8*MAX_BYTES)'(24'hFF00FF);

  localparam logic [2:0] C_ZERO = 3'd0, C_ONE = 3'd1, C_HALF = 3'd2,
                         C_EOP = 3'd3, C_CUT = 3'd4, C_POST = 3'd5;

  typedef enum logic [2:0] {S_PRE, S_DATA, S_SEP, S_TAIL, S_NOCUT, S_C1, S_C2, S_C3} st_t;

  st_t                          st;
  logic [CNT_W-1:0]             cnt;
  logic                         hz_r, idle_r;
  logic [MAX_BYTES-1:0][7:0]    data_r;
  logic [LEN_W-1:0]             len_r;
  logic [REP_W:0]               rep_left;
  logic [BYTE_W-1:0]            byte_i;
  logic [2:0]                   bit_i;
  logic [2:0]                   tc;

  wire              hz_cur = (cnt == '0) ? half_zero_en : hz_r;
  wire [CNT_W-1:0]  need   = hz_cur ? NEED_HZ : NEED_PLAIN;
  wire              at_end = sym_done && ((st == S_C3) || (st == S_NOCUT && tc == 3'd4));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_PRE; cnt <= '0; hz_r <= 1'b0; idle_r <= 1'b0;
      data_r <= '0; len_r <= '0; rep_left <= '0; byte_i <= '0; bit_i <= 3'd7; tc <= '0;
      sym_load <= 1'b0; sym_code <= C_ONE; pkt_ready <= 1'b0; pkt_next <= 1'b0;
      cut_open <= 1'b0; cut_phase <= 2'd0; cut_len_us <= '0; cut_en <= '0;
    end else begin
      sym_load  <= sym_done;
      pkt_ready <= 1'b0;
      pkt_next  <= 1'b0;
      if (sym_done) begin
        cut_open   <= 1'b0;
        cut_len_us <= '0;
        case (st)
          S_PRE: begin
            if (cnt >= need) begin
              sym_code <= C_ZERO;
              st <= S_DATA; byte_i <= '0; bit_i <= 3'd7; cnt <= '0;
              if (rep_left == '0) begin
                if (pkt_valid) begin
                  data_r <= pkt_data; len_r <= pkt_len;
                  rep_left <= {1'b0, pkt_repeat} + 1'b1; idle_r <= 1'b0;
                end else begin
                  data_r <= IDLE_PKT; len_r <= LEN_W'(3);
                  rep_left <= (REP_W+1)'(1); idle_r <= 1'b1;
                end
              end
            end else begin
              sym_code <= (cnt == '0 && half_zero_en) ? C_HALF : C_ONE;
              if (cnt == '0) hz_r <= half_zero_en;
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            sym_code <= {2'b00, data_r[byte_i][bit_i]};
            if (bit_i == 3'd0) st <= S_SEP;
            else bit_i <= bit_i - 1'b1;
          end
          S_SEP: begin
            if (LEN_W'(byte_i) + 1'b1 >= len_r) begin
              sym_code <= C_ONE; st <= S_TAIL;
            end else begin
              sym_code <= C_ZERO; byte_i <= byte_i + 1'b1; bit_i <= 3'd7; st <= S_DATA;
            end
          end
          S_TAIL: begin
            if (|cutout_req) begin
              sym_code <= C_CUT; cut_open <= 1'b1; cut_phase <= 2'd0;
              cut_len_us <= 10'(CUT_PRE_US); st <= S_C1;
            end else begin
              sym_code <= C_ONE; tc <= 3'd1; st <= S_NOCUT;
            end
          end
          S_C1: begin
            sym_code <= C_CUT; cut_open <= 1'b1; cut_phase <= 2'd1;
            cut_len_us <= 10'(CUT_FIRST_US); cut_en <= cutout_req; st <= S_C2;
          end
          S_C2: begin
            sym_code <= C_CUT; cut_open <= 1'b1; cut_phase <= 2'd2;
            cut_len_us <= 10'(CUT_MID_US); st <= S_C3;
          end
          S_C3: begin
            sym_code <= C_POST; cut_open <= 1'b1; cut_phase <= 2'd3;
            cut_len_us <= 10'(CUT_POST_US); cut_en <= '0;
          end
          S_NOCUT: begin
            if (tc < 3'd4) begin
              sym_code <= C_ONE; tc <= tc + 1'b1;
            end else begin
              sym_code <= C_EOP; tc <= '0;
            end
          end
          default: st <= S_PRE;
        endcase
        if (at_end) begin
          st <= S_PRE; cnt <= '0; pkt_next <= 1'b1;
          if (rep_left <= (REP_W+1)'(1)) begin
            rep_left <= '0; pkt_ready <= !idle_r;
          end else begin
            rep_left <= rep_left - 1'b1;
          end
        end
      end
    end
  end

  AST_LOAD_PER_DONE:    assert property (@(posedge clk) disable iff (rst) sym_done |=> sym_load); // R2
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (rst) !sym_done |=> !sym_load); // R2
  AST_CODE_LEGAL:       assert property (@(posedge clk) disable iff (rst) sym_code <= C_POST); // R2
  AST_EOP_ENDS_PACKET:  assert property (@(posedge clk) disable iff (rst) (sym_load && sym_code == C_EOP) |-> pkt_next); // R6
  AST_PHASE_ORDER:      assert property (@(posedge clk) disable iff (rst)
                          (sym_load && cut_open && cut_phase == 2'd1) |-> $past(cut_open) && $past(cut_phase) == 2'd0); // R7
  AST_EN_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst) (|cut_en) |-> cut_open); // R8
  AST_POST_DROPS_EN:    assert property (@(posedge clk) disable iff (rst)
                          (sym_load && cut_open && cut_phase == 2'd3) |-> cut_en == '0); // R8
  AST_POP_AT_END:       assert property (@(posedge clk) disable iff (rst) pkt_ready |-> pkt_next); // R10
endmodule

// File: tb/test_dcc_bit_sequencer.sv
module test_dcc_bit_sequencer;
  localparam int MB = 6;
  localparam int PLEN = 17;
  localparam int NO = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic pkt_valid = 1'b0, half_zero_en = 1'b0, sym_done = 1'b0;
  logic [8*MB-1:0] pkt_data = '0;
  logic [2:0] pkt_len = '0;
  logic [2:0] pkt_repeat = '0;
  logic [NO-1:0] cutout_req = '0;
  logic pkt_ready, sym_load, pkt_next, cut_open;
  logic [2:0] sym_code;
  logic [1:0] cut_phase;
  logic [9:0] cut_len_us;
  logic [NO-1:0] cut_en;

  int checks = 0, errors = 0;
  logic [2:0] exp_codes [0:159];
  int exp_n;

  always #10 clk = ~clk;

  dcc_bit_sequencer i_dcc_bit_sequencer (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_len(pkt_len), .pkt_repeat(pkt_repeat),
    .half_zero_en(half_zero_en), .cutout_req(cutout_req), .sym_done(sym_done),
    .sym_load(sym_load), .sym_code(sym_code), .pkt_next(pkt_next),
    .cut_open(cut_open), .cut_phase(cut_phase), .cut_len_us(cut_len_us), .cut_en(cut_en));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic slot();
    @(negedge clk); sym_done = 1'b1;
    @(negedge clk); sym_done = 1'b0;
  endtask

  task automatic build(input logic [8*MB-1:0] d, input int len, input bit hz, input bit cut);
    exp_n = 0;
    if (hz) begin
      exp_codes[exp_n++] = 3'd2;
      for (int i = 0; i < 20; i++) exp_codes[exp_n++] = 3'd1;
    end else
      for (int i = 0; i < PLEN-1; i++) exp_codes[exp_n++] = 3'd1;
    exp_codes[exp_n++] = 3'd0;
    for (int b = 0; b < len; b++) begin
      for (int k = 7; k >= 0; k--) exp_codes[exp_n++] = {2'b00, d[8*b+k]};
      exp_codes[exp_n++] = (b == len-1) ? 3'd1 : 3'd0;
    end
    if (cut) begin
      exp_codes[exp_n++] = 3'd4; exp_codes[exp_n++] = 3'd4;
      exp_codes[exp_n++] = 3'd4; exp_codes[exp_n++] = 3'd5;
    end else begin
      for (int i = 0; i < 4; i++) exp_codes[exp_n++] = 3'd1;
      exp_codes[exp_n++] = 3'd3;
    end
  endtask

  // Runs one packet slot; the packet is offered at slot arm_at when offer is set.
  task automatic run_packet(input string req, input logic [8*MB-1:0] d, input int len,
                            input int rep, input bit offer, input int arm_at,
                            input bit hz, input bit exp_ready, input logic [8*MB-1:0] exp_d);
    int bad_code = 0, bad_next = 0, bad_ready = 0, bad_load = 0, bad_cut = 0;
    int first_bad = -1, got_first = 0, exp_first = 0;
    bit cut = |cutout_req;
    half_zero_en = hz;
    build(exp_d, len, hz, cut);
    for (int i = 0; i < exp_n; i++) begin
      if (offer && i == arm_at) begin
        pkt_valid = 1'b1; pkt_data = d; pkt_len = 3'(len); pkt_repeat = 3'(rep);
      end
      slot();
      if (!sym_load) bad_load++;
      if (sym_code != exp_codes[i]) begin
        if (first_bad < 0) begin first_bad = i; got_first = sym_code; exp_first = exp_codes[i]; end
        bad_code++;
      end
      if (pkt_next != (i == exp_n-1)) bad_next++;
      if (pkt_ready != (exp_ready && i == exp_n-1)) bad_ready++;
      if (pkt_ready) pkt_valid = 1'b0;
      if (cut && i >= exp_n-4) begin
        int k = i - (exp_n-4);
        int elen = (k == 0) ? 26 : (k == 1) ? 160 : (k == 2) ? 190 : 504-26-160-190;
        if (!cut_open || cut_phase != 2'(k) || cut_len_us != 10'(elen)) bad_cut++;
        if (cut_en != ((k == 1 || k == 2) ? cutout_req : '0)) bad_cut++;
      end else if (cut_open || cut_en != '0) bad_cut++;
    end
    if (bad_code != 0) chk(req, $sformatf("symbol %0d code", first_bad), got_first, exp_first);
    else chk(req, "symbol codes", 0, 0);
    chk("R2", "missing loads", bad_load, 0);
    chk("R10", "pkt_next misplaced", bad_next, 0);
    chk(exp_ready ? "R10" : "R10/R11", "pkt_ready misplaced", bad_ready, 0);
    chk(cut ? "R7 R8 R9" : "R6 R8", "cutout outputs wrong", bad_cut, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "code in reset", sym_code, 1);
    chk("R1", "flags in reset", {sym_load, pkt_ready, pkt_next, cut_open, |cut_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "load idle after reset", sym_load, 0);
  endtask

  task automatic t_basic();   // R3 R5 R6 R12: offered after five preamble slots
    cutout_req = '0;
    run_packet("R3 R5 R6 R12", 48'h3C_A5, 2, 0, 1'b1, 5, 1'b0, 1'b1, 48'h3C_A5);
  endtask

  task automatic t_repeat();  // R10: repeat 2 gives three passes
    cutout_req = '0;
    run_packet("R10 pass1", 48'h81, 1, 2, 1'b1, 0, 1'b0, 1'b0, 48'h81);
    run_packet("R10 pass2", 48'h81, 1, 2, 1'b0, 0, 1'b0, 1'b0, 48'h81);
    run_packet("R10 pass3", 48'h81, 1, 2, 1'b0, 0, 1'b0, 1'b1, 48'h81);
    chk("R10", "queue popped after final pass", pkt_valid, 0);
  endtask

  task automatic t_cutout();  // R4 R7 R8 R9
    cutout_req = 3'b101;
    run_packet("R4 R5 R7", 48'h0F_C3_96, 3, 0, 1'b1, 0, 1'b1, 1'b1, 48'h0F_C3_96);
    cutout_req = '0;
  endtask

  task automatic t_idle();    // R11
    cutout_req = '0;
    run_packet("R11", '0, 3, 0, 1'b0, 0, 1'b0, 1'b0, 48'hFF00FF);
  endtask

  task automatic t_gap();     // R2: no done, no load, code held
    logic [2:0] held;
    int bad = 0;
    held = sym_code;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sym_load || sym_code != held) bad++;
    end
    chk("R2", "output changed without done", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_repeat();
    t_cutout();
    t_idle();
    t_gap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule